// File: doc/BRIEF.md
# Stereo I2S to Cascaded-DAC SPI Bridge

This block takes a stereo I2S stream and turns it into SPI writes for two precision DACs wired in a daisy chain, one DAC per channel. The I2S stream carries 24-bit samples right-justified in 32-bit slots. The block runs entirely from the incoming bit clock. It rewrites each slot as the bits pass through: the unused top byte of the slot is replaced by a fixed address byte, and the sample's sign bit is flipped so that the DAC receives offset-binary code.

Each rising edge of the left-right clock starts a 64-bit chain frame. The SPI chip select marks that edge with a high pulse one bit clock long. Once a complete frame has gone out, an active-low load strobe tells both DACs to update their outputs at the same moment. The SPI clock is the inverse of the bit clock, so the DAC samples each data bit half a period after it changes.

Top module: `i2s_dac_chain_bridge`

## Requirements
- R1: `spi_sclk` is always the logical inverse of `bclk`. `spi_sdo`, `spi_cs_n` and `dac_load_n` change only on rising edges of `bclk`, so every bit is stable at the rising edge of `spi_sclk`.
- R2: When `lrclk` is sampled high on a `bclk` rising edge after being sampled low on the previous edge, `spi_cs_n` is driven high for exactly one bit clock starting at that edge. This window coincides with the leading (always 0) address bit. Once the first such edge has occurred, `spi_cs_n` is low at all other times.
- R3: Bits 0 to 7 of each 32-bit SPI word carry the address byte 0x01, MSB first, whatever the slot's upper byte held on `sdata`.
- R4: Bits 8 to 31 of each SPI word are the 24 slot sample bits, MSB first and unshifted, with the sample MSB inverted (two's complement in, offset binary out).
- R5: The frame that starts at an `lrclk` rising edge has 64 bits. The first word comes from the slot with `lrclk` high (right channel) and the second from the following slot with `lrclk` low (left channel). Each output bit appears on the same edge that samples the matching `sdata` bit.
- R6: `dac_load_n` goes low for exactly two bit clocks, starting two bit clocks after `spi_cs_n` goes high. It does so only when the preceding frame lasted exactly 64 bit clocks. It is never low while `spi_cs_n` is high.
- R7: During reset, `spi_cs_n` and `dac_load_n` are high. After reset, `spi_cs_n` stays high until the first `lrclk` rising edge, and that first pulse produces no load strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | I2S bit clock, the block's only clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lrclk | input | 1 | I2S word select, high = right slot |
| sdata | input | 1 | I2S serial data, right-justified 24-bit samples in 32-bit slots |
| spi_sclk | output | 1 | SPI clock, inverse of `bclk` |
| spi_sdo | output | 1 | SPI serial data to the first DAC of the chain |
| spi_cs_n | output | 1 | Active-low chip select, high one bit clock per frame |
| dac_load_n | output | 1 | Active-low shared DAC update strobe |

## Verification
Two functions can fall in the same cycle. The load strobe for a finished frame fires while the next frame's address byte is being shifted out, and the chip-select pulse of that next frame coincides with its leading address bit. The bench provokes this by sending frames back to back from the first slot onward. In every cycle it compares chip select, load strobe and data against a model built from the requirements, and it reassembles each frame to check the address bytes, flipped samples and word order. A truncated slot near the end produces a 48-bit frame; the bench checks that the next chip-select pulse from that frame brings no strobe, while the full frames on either side of it still do.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

  localparam int unsigned IBR_SLOT_BITS   = 32;
  localparam int unsigned IBR_SAMPLE_BITS = 24;
  localparam int unsigned IBR_ADDR_VAL    = 1;
  localparam int unsigned IBR_LOAD_DELAY  = 2;
  localparam int unsigned IBR_LOAD_WIDTH  = 2;

  typedef struct packed {
    logic cs_n;
    logic load_n;
  } ibr_ctl_t;

endpackage

// File: rtl/ibr_rst_sync.sv
module ibr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/ibr_lr_tracker.sv
module ibr_lr_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic lr_i,
  output logic rise_o,
  output logic change_o
);
  logic lr_q;
  logic lr_d;

  always_comb begin
    lr_d = lr_i;
  end

  // reset high so that an lrclk already high at release is not taken as an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lr_q <= 1'b1;
    else        lr_q <= lr_d;
  end

  assign rise_o   = lr_i & ~lr_q;
  assign change_o = lr_i ^ lr_q;
endmodule

// File: rtl/ibr_slot_rewriter.sv
module ibr_slot_rewriter #(
  parameter int unsigned SLOT_BITS   = 32,
  parameter int unsigned SAMPLE_BITS = 24,
  parameter int unsigned ADDR_VAL    = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic change_i,
  input  logic sd_i,
  output logic sdo_o
);
  localparam int unsigned PAD   = SLOT_BITS - SAMPLE_BITS;
  localparam int unsigned IDX_W = $clog2(SLOT_BITS);
  localparam logic [PAD-1:0]   ADDR_BITS = PAD'(ADDR_VAL);
  localparam logic [IDX_W-1:0] PAD_IDX   = IDX_W'(PAD);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(SLOT_BITS - 1);

  logic [IDX_W-1:0] idx_q, idx_d, idx_cur;
  logic [PAD-1:0]   addr_sh;
  logic             sdo_q, sdo_d;

  always_comb begin
    idx_cur = change_i ? '0 : idx_q;
    addr_sh = ADDR_BITS << idx_cur;
    if (idx_cur < PAD_IDX)       sdo_d = addr_sh[PAD-1];
    else if (idx_cur == PAD_IDX) sdo_d = ~sd_i;
    else                         sdo_d = sd_i;
    idx_d = (idx_cur == LAST_IDX) ? '0 : idx_cur + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      sdo_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      sdo_q <= sdo_d;
    end
  end

  assign sdo_o = sdo_q;
endmodule

// File: rtl/ibr_frame_ctrl.sv
module ibr_frame_ctrl
  import ibr_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 64,
  parameter int unsigned LOAD_DELAY = 2,
  parameter int unsigned LOAD_WIDTH = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rise_i,
  output ibr_ctl_t ctl_o
);
  localparam int unsigned LOAD_END = LOAD_DELAY + LOAD_WIDTH;
  localparam int unsigned BC_W = $clog2(FRAME_BITS + 1);
  localparam int unsigned LC_W = $clog2(LOAD_END + 1);
  localparam logic [BC_W-1:0] BC_FULL = BC_W'(FRAME_BITS - 1);
  localparam logic [BC_W-1:0] BC_SAT  = BC_W'(FRAME_BITS);
  localparam logic [LC_W-1:0] LC_ON   = LC_W'(LOAD_DELAY);
  localparam logic [LC_W-1:0] LC_OFF  = LC_W'(LOAD_END);
  localparam logic [LC_W-1:0] LC_ONE  = LC_W'(1);

  logic            started_q, started_d;
  logic [BC_W-1:0] bc_q, bc_d;
  logic [LC_W-1:0] lc_q, lc_d;
  logic            bc_en, lc_en, full_frame;
  ibr_ctl_t        ctl_q, ctl_d;

  always_comb begin
    full_frame = started_q && (bc_q == BC_FULL);
    started_d  = started_q | rise_i;
    bc_en      = rise_i || (bc_q != BC_SAT);
    bc_d       = rise_i ? '0 : bc_q + 1'b1;
    lc_en      = (rise_i && full_frame) || (lc_q != '0);
    if (rise_i && full_frame) lc_d = LC_ONE;
    else if (lc_q == LC_OFF)  lc_d = '0;
    else                      lc_d = lc_q + 1'b1;
    ctl_d.cs_n   = rise_i | ~started_q;
    ctl_d.load_n = ~((lc_q >= LC_ON) && (lc_q < LC_OFF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      bc_q      <= BC_SAT;
      lc_q      <= '0;
      ctl_q     <= '{cs_n: 1'b1, load_n: 1'b1};
    end else begin
      started_q <= started_d;
      if (bc_en) bc_q <= bc_d;
      if (lc_en) lc_q <= lc_d;
      ctl_q <= ctl_d;
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/i2s_dac_chain_bridge.sv
module i2s_dac_chain_bridge
  import ibr_pkg::*;
#(
  parameter int unsigned SLOT_BITS   = IBR_SLOT_BITS,
  parameter int unsigned SAMPLE_BITS = IBR_SAMPLE_BITS,
  parameter int unsigned ADDR_VAL    = IBR_ADDR_VAL,
  parameter int unsigned LOAD_DELAY  = IBR_LOAD_DELAY,
  parameter int unsigned LOAD_WIDTH  = IBR_LOAD_WIDTH,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic bclk,
  input  logic rst_n,
  input  logic lrclk,
  input  logic sdata,
  output logic spi_sclk,
  output logic spi_sdo,
  output logic spi_cs_n,
  output logic dac_load_n
);
  localparam int unsigned FRAME_BITS = 2 * SLOT_BITS;

  logic     rst_sync_n;
  logic     lr_rise, lr_change;
  ibr_ctl_t ctl;

  ibr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(bclk), .arst_n(rst_n), .rst_n_o(rst_sync_n)
  );

  ibr_lr_tracker u_lr (
    .clk(bclk), .rst_n(rst_sync_n), .lr_i(lrclk),
    .rise_o(lr_rise), .change_o(lr_change)
  );

  ibr_slot_rewriter #(
    .SLOT_BITS(SLOT_BITS), .SAMPLE_BITS(SAMPLE_BITS), .ADDR_VAL(ADDR_VAL)
  ) u_rw (
    .clk(bclk), .rst_n(rst_sync_n), .change_i(lr_change),
    .sd_i(sdata), .sdo_o(spi_sdo)
  );

  ibr_frame_ctrl #(
    .FRAME_BITS(FRAME_BITS), .LOAD_DELAY(LOAD_DELAY), .LOAD_WIDTH(LOAD_WIDTH)
  ) u_fc (
    .clk(bclk), .rst_n(rst_sync_n), .rise_i(lr_rise), .ctl_o(ctl)
  );

  assign spi_sclk   = ~bclk;
  assign spi_cs_n   = ctl.cs_n;
  assign dac_load_n = ctl.load_n;
endmodule

// File: rtl/i2s_dac_chain_bridge_chk.sv
module i2s_dac_chain_bridge_chk #(
  parameter bit LEAD_BIT = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic lrclk,
  input logic sdo,
  input logic cs_n,
  input logic load_n
);
  // R2: a sampled lrclk rising edge raises chip select on the next cycle
  a_r2_cs_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lrclk) |=> cs_n);

  // R2: a chip-select high window lasts a single bit clock
  a_r2_cs_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !$past(cs_n)) |=> !cs_n);

  // R3: the bit shifted during the chip-select pulse is the address MSB
  a_r3_lead_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !$past(cs_n)) |-> (sdo == LEAD_BIT));

  // R6: strobe never overlaps the chip-select high window
  a_r6_load_outside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |-> !cs_n);

  // R6: strobe starts two bit clocks after the chip-select pulse began
  a_r6_load_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_n) |-> ($past(cs_n, 2) && !$past(cs_n, 1)));

  // R6: strobe is two bit clocks wide
  a_r6_load_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_n) |=> !load_n);

  a_r6_load_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_n) |-> ##2 load_n);
endmodule

bind i2s_dac_chain_bridge i2s_dac_chain_bridge_chk u_chk (
  .clk(bclk), .rst_n(rst_sync_n), .lrclk(lrclk),
  .sdo(spi_sdo), .cs_n(spi_cs_n), .load_n(dac_load_n)
);

// File: tb/i2s_dac_chain_bridge_bench.sv
`timescale 1ns/100ps
module i2s_dac_chain_bridge_bench;
  localparam int NP = 40;

  logic bclk = 1'b0;
  logic rst_n, lrclk, sdata;
  logic spi_sclk, spi_sdo, spi_cs_n, dac_load_n;

  always #2.5 bclk = ~bclk;

  i2s_dac_chain_bridge u_i2s_dac_chain_bridge (
    .bclk(bclk), .rst_n(rst_n), .lrclk(lrclk), .sdata(sdata),
    .spi_sclk(spi_sclk), .spi_sdo(spi_sdo), .spi_cs_n(spi_cs_n),
    .dac_load_n(dac_load_n)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [23:0] lsmp [0:NP];
  logic [23:0] rsmp [0:NP-1];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic drive_slot(input logic lr, input int nbits, input logic [31:0] word);
    for (int i = 0; i < nbits; i++) begin
      @(negedge bclk);
      lrclk = lr;
      sdata = word[31-i];
    end
  endtask

  // monitor: samples 1 ns after each rising bclk edge
  bit          mon_en = 0, started = 0, lr_prev = 1, load_due = 0, ld_prev = 1;
  int          nbits = 0, fidx = 0, off = 10, nfalls = 0;
  logic [63:0] cap = '0;
  bit          rise, exp_cs, exp_ld;

  always @(posedge bclk) begin
    #1;
    if (mon_en) begin
      chk(spi_sclk == 1'b0, "R1", {63'd0, spi_sclk}, 64'd0);
      rise = lrclk && !lr_prev;
      lr_prev = lrclk;
      if (rise) begin
        load_due = started && (nbits == 64);
        if (started) fidx++;
        started = 1; nbits = 0; off = 0;
      end
      exp_cs = rise || !started;
      chk(spi_cs_n == exp_cs, rise ? "R2" : (started ? "R2" : "R7"), {63'd0, spi_cs_n}, {63'd0, exp_cs});
      if (started && nbits < 64) begin
        cap = {cap[62:0], spi_sdo};
        nbits++;
        if (nbits == 64 && fidx < NP) begin
          chk(cap[63:56] == 8'h01 && cap[31:24] == 8'h01, "R3", cap, {8'h01, 24'h0, 8'h01, 24'h0});
          chk(cap[55:32] == (rsmp[fidx] ^ 24'h800000), "R4/R5 right word", {40'd0, cap[55:32]}, {40'd0, rsmp[fidx] ^ 24'h800000});
          chk(cap[23:0] == (lsmp[fidx+1] ^ 24'h800000), "R4/R5 left word", {40'd0, cap[23:0]}, {40'd0, lsmp[fidx+1] ^ 24'h800000});
        end
      end
      exp_ld = !(load_due && (off == 2 || off == 3));
      chk(dac_load_n == exp_ld, load_due ? "R6" : "R7", {63'd0, dac_load_n}, {63'd0, exp_ld});
      if (off < 10) off++;
      if (ld_prev && !dac_load_n) nfalls++;
      ld_prev = dac_load_n;
    end
  end

  initial begin
    lsmp[0] = 24'h000000; rsmp[0] = 24'h7FFFFF;
    lsmp[1] = 24'h800000; rsmp[1] = 24'hFFFFFF;
    lsmp[2] = 24'h000001; rsmp[2] = 24'h800001;
    lsmp[3] = 24'hAAAAAA; rsmp[3] = 24'h555555;
    for (int k = 4; k < NP; k++) begin
      lsmp[k] = 24'($urandom);
      rsmp[k] = 24'($urandom);
    end
    lsmp[NP] = 24'($urandom);

    rst_n = 1'b0; lrclk = 1'b0; sdata = 1'b0;
    repeat (4) @(negedge bclk);
    chk(spi_cs_n == 1'b1, "R7", {63'd0, spi_cs_n}, 64'd1);
    chk(dac_load_n == 1'b1, "R7", {63'd0, dac_load_n}, 64'd1);
    rst_n = 1'b1;
    mon_en = 1;
    repeat (8) @(negedge bclk);

    for (int k = 0; k < NP; k++) begin
      drive_slot(1'b0, 32, {8'($urandom), lsmp[k]});
      drive_slot(1'b1, 32, {8'($urandom), rsmp[k]});
    end
    drive_slot(1'b0, 32, {8'($urandom), lsmp[NP]});
    drive_slot(1'b1, 16, $urandom);          // truncated right slot
    drive_slot(1'b0, 32, $urandom);
    drive_slot(1'b1, 32, $urandom);          // closes the 48-bit frame: no strobe
    drive_slot(1'b0, 32, $urandom);
    drive_slot(1'b1, 24, $urandom);          // closes a full frame: strobe
    repeat (10) @(negedge bclk);

    chk(nfalls == NP + 1, "R6 strobe count", 64'(nfalls), 64'(NP + 1));
    chk(fidx == NP + 2, "R2 frame count", 64'(fidx), 64'(NP + 2));
    done = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge bclk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end
endmodule